// File: doc/BRIEF.md
# Real-Time Tick Counter with Wrap Flag

This block is a real-time clock peripheral for a 16-bit processor. A prescaler divides the system clock down to a tick rate that defaults to 1000 ticks per second. Every tick adds one to a counter word. Software can load that word and read it back. When an increment carries the counter from all ones to zero, a wrap flag is set. That flag can be routed to an interrupt request and tested with a skip query.

Software controls the clock with a three-bit command word that is sampled on a strobe. One bit halts the clock, one starts it, and one clears the wrap flag. A start command given while the clock is already running is ignored, so the tick phase is not disturbed. The divisor is computed from two parameters, the system clock frequency and the tick rate.

Top module: `rtc_tick_clock`

## Requirements
- R1: After reset the counter is 0, the wrap flag is 0, the clock is stopped (`running_o`=0), and `irq_o` and `skip_o` are 0.
- R2: While the clock runs, `count_o` increases by one every DIV cycles (DIV = CLK_HZ/TICK_HZ) and wraps modulo 2^16. While the clock is stopped, the counter holds its value.
- R3: A tick that takes the counter from 16'hFFFF to 0 sets the wrap flag on the same edge. A load of the value 0 does not set the flag.
- R4: A strobed command with bit 0 (halt) set stops the clock on that edge. Any tick due in that cycle is suppressed, and no further increments occur.
- R5: A strobed command with only bit 1 (start) set has no effect on a running clock. The next tick arrives on the same cycle it would have arrived without the command.
- R6: A start command given while the clock is stopped, or a command with both halt and start set, runs the clock with the prescaler reset to zero. The first increment becomes visible DIV cycles after the edge that accepts the command.
- R7: `ld_en` writes `ld_data` into the counter on the next edge. The load takes priority over a tick in the same cycle, and that tick is lost.
- R8: A strobed command with bit 2 set clears the wrap flag. `skip_o` equals `skip_sel` AND the wrap flag. Command bits are ignored while `fn_strobe` is low.
- R9: `irq_o` equals the wrap flag AND `irq_enable`.
- R10: If a clear command and a wrapping tick fall in the same cycle, the wrap flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fn_strobe | input | 1 | Qualifies `fn_word` for one cycle |
| fn_word | input | 3 | Command: bit0 halt, bit1 start, bit2 clear wrap flag |
| ld_en | input | 1 | Load the counter |
| ld_data | input | CNT_W | Value to load |
| irq_enable | input | 1 | Routes the wrap flag to `irq_o` |
| skip_sel | input | 1 | Selects the wrap flag for the skip test |
| count_o | output | CNT_W | Current counter value |
| wrap_flag_o | output | 1 | Wrap (overflow ready) flag |
| running_o | output | 1 | The clock is running |
| skip_o | output | 1 | Skip-test result |
| irq_o | output | 1 | Interrupt request |

## Verification
The counting path is driven in several ways: a free run after a cold start, loads near 16'hFFFF that force a wrap, and loads issued on the exact cycle a tick is due. Together these separate a correct increment from a lost or doubled tick, and a wrap-set flag from a load-set one. Start commands are sent both while the clock is stopped and while it is running. A phase that is restarted when it should have been kept shows up as a shifted tick. Halt commands land on tick-due cycles, and clear commands land on wrap cycles, to resolve the priorities. A long stretch of seeded random commands, loads and enable changes then compares every output on every cycle against a model in the bench.

// File: rtl/rtk_pkg.sv
package rtk_pkg;
    localparam int FN_W = 3;

    // command word layout: bit0 halt, bit1 start, bit2 clear wrap flag
    typedef struct packed {
        logic clr_wrap;
        logic go;
        logic halt;
    } fn_cmd_t;
endpackage

// File: rtl/rtk_prescaler.sv
module rtk_prescaler #(
    parameter int DIV = 125000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_i,
    input  logic go_i,
    output logic tick_o,
    output logic run_o
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic          run;
        logic [PW-1:0] ph;
    } st_t;

    st_t  s_d, s_q;
    logic last;

    assign last  = (s_q.ph == PW'(DIV - 1));
    assign run_o = s_q.run;

    always_comb begin
        s_d    = s_q;
        tick_o = 1'b0;
        if (halt_i) begin
            s_d.run = go_i;
            s_d.ph  = '0;
        end else if (go_i && !s_q.run) begin
            s_d.run = 1'b1;
            s_d.ph  = '0;
        end else if (s_q.run) begin
            if (last) begin
                s_d.ph = '0;
                tick_o = 1'b1;
            end else begin
                s_d.ph = s_q.ph + PW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R4
    halt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_i && !go_i) |=> !s_q.run);
    // R5
    keep_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && go_i && !halt_i && !last) |=> (s_q.run && s_q.ph == $past(s_q.ph) + PW'(1)));
    // R6
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_i && go_i) |=> (s_q.run && s_q.ph == '0));
endmodule

// File: rtl/rtk_counter.sv
module rtk_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         ld_i,
    input  logic [W-1:0] ld_val_i,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o,
    output logic         flag_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         flag;
    } st_t;

    st_t  s_d, s_q;
    logic inc, wrap;

    assign inc    = tick_i && !ld_i;
    assign wrap   = inc && (&s_q.cnt);
    assign cnt_o  = s_q.cnt;
    assign flag_o = s_q.flag;

    always_comb begin
        s_d = s_q;
        if (ld_i)     s_d.cnt = ld_val_i;
        else if (inc) s_d.cnt = s_q.cnt + W'(1);
        if (wrap)       s_d.flag = 1'b1;
        else if (clr_i) s_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3 R10
    wrap_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !ld_i && s_q.cnt == {W{1'b1}}) |=> (s_q.flag && s_q.cnt == '0));
    // R7
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i |=> (s_q.cnt == $past(ld_val_i)));
    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !ld_i) |=> $stable(s_q.cnt));
endmodule

// File: rtl/rtc_tick_clock.sv
module rtc_tick_clock #(
    parameter int CLK_HZ  = 125000000,
    parameter int TICK_HZ = 1000,
    parameter int CNT_W   = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fn_strobe,
    input  logic [rtk_pkg::FN_W-1:0] fn_word,
    input  logic                    ld_en,
    input  logic [CNT_W-1:0]        ld_data,
    input  logic                    irq_enable,
    input  logic                    skip_sel,
    output logic [CNT_W-1:0]        count_o,
    output logic                    wrap_flag_o,
    output logic                    running_o,
    output logic                    skip_o,
    output logic                    irq_o
);
    import rtk_pkg::*;

    localparam int DIV = CLK_HZ / TICK_HZ;

    fn_cmd_t cmd;
    logic    tick;

    assign cmd = fn_strobe ? fn_cmd_t'(fn_word) : '0;

    rtk_prescaler #(.DIV(DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .halt_i(cmd.halt),
        .go_i  (cmd.go),
        .tick_o(tick),
        .run_o (running_o)
    );

    rtk_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .ld_i    (ld_en),
        .ld_val_i(ld_data),
        .clr_i   (cmd.clr_wrap),
        .cnt_o   (count_o),
        .flag_o  (wrap_flag_o)
    );

    assign skip_o = skip_sel && wrap_flag_o;
    assign irq_o  = irq_enable && wrap_flag_o;

    // R4
    no_tick_after_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running_o && !ld_en) |=> $stable(count_o));
endmodule

// File: tb/rtc_tick_clock_test.sv
module rtc_tick_clock_test;
    localparam int CLK_HZ  = 8000;
    localparam int TICK_HZ = 1000;
    localparam int DIV     = CLK_HZ / TICK_HZ;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fn_strobe = 1'b0;
    logic [2:0]  fn_word = '0;
    logic        ld_en = 1'b0;
    logic [15:0] ld_data = '0;
    logic        irq_enable = 1'b0;
    logic        skip_sel = 1'b0;
    logic [15:0] count_o;
    logic        wrap_flag_o, running_o, skip_o, irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    string tag = "R1";

    // bench model state
    bit          m_run;
    int          m_ph;
    logic [15:0] m_cnt;
    bit          m_flag;

    rtc_tick_clock #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .CNT_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .fn_strobe(fn_strobe), .fn_word(fn_word),
        .ld_en(ld_en), .ld_data(ld_data), .irq_enable(irq_enable), .skip_sel(skip_sel),
        .count_o(count_o), .wrap_flag_o(wrap_flag_o), .running_o(running_o),
        .skip_o(skip_o), .irq_o(irq_o)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit tick_due(input bit hs);
        return m_run && (m_ph == DIV - 1) && !hs;
    endfunction

    task automatic compare_all();
        check(tag, {16'h0, count_o}, {16'h0, m_cnt}, "count");
        check(tag, {31'h0, wrap_flag_o}, {31'h0, m_flag}, "wrap flag");
        check(tag, {31'h0, running_o}, {31'h0, m_run}, "running");
        check(tag, {31'h0, skip_o}, {31'h0, skip_sel & m_flag}, "skip (R8)");
        check(tag, {31'h0, irq_o}, {31'h0, irq_enable & m_flag}, "irq (R9)");
    endtask

    // one cycle: inputs already driven at a negedge
    task automatic step();
        bit hs, go, cl, tk, wr;
        bit          n_run;
        int          n_ph;
        logic [15:0] n_cnt;
        bit          n_flag;
        hs = fn_strobe & fn_word[0];
        go = fn_strobe & fn_word[1];
        cl = fn_strobe & fn_word[2];
        tk = tick_due(hs);
        n_run = m_run; n_ph = m_ph;
        if (hs) begin n_run = go; n_ph = 0; end
        else if (go && !m_run) begin n_run = 1; n_ph = 0; end
        else if (m_run) n_ph = (m_ph == DIV - 1) ? 0 : m_ph + 1;
        n_cnt = m_cnt;
        wr = 0;
        if (ld_en) n_cnt = ld_data;
        else if (tk) begin n_cnt = m_cnt + 16'd1; wr = (m_cnt == 16'hFFFF); end
        n_flag = wr ? 1'b1 : (cl ? 1'b0 : m_flag);
        @(posedge clk);
        m_run = n_run; m_ph = n_ph; m_cnt = n_cnt; m_flag = n_flag;
        @(negedge clk);
        fn_strobe = 0; ld_en = 0;
        compare_all();
    endtask

    task automatic cmd(input logic [2:0] w);
        fn_strobe = 1; fn_word = w; step();
    endtask

    task automatic load(input logic [15:0] v);
        ld_en = 1; ld_data = v; step();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wait_due();
        for (int i = 0; i < DIV + 1 && !(m_run && m_ph == DIV - 1); i++) step();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int seed;
        logic [15:0] snap;
        seed = $urandom(32'd1234);
        m_run = 0; m_ph = 0; m_cnt = 0; m_flag = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        tag = "R1"; compare_all();
        idle(2);

        tag = "R6"; cmd(3'b010); idle(DIV + 3);
        // halt and start together restarts the phase
        idle(3); cmd(3'b011); idle(DIV + 1);

        tag = "R5";
        idle(2); snap = m_cnt;
        cmd(3'b010); idle(DIV * 2);
        check("R5", {16'h0, count_o}, {16'h0, snap + 16'd2}, "two ticks after idle start");

        tag = "R7"; wait_due(); load(16'h1234);
        check("R7", {16'h0, count_o}, 32'h1234, "load beats tick");
        idle(DIV);

        tag = "R3"; load(16'hFFFF); idle(DIV + 1);
        check("R3", {31'h0, wrap_flag_o}, 32'h1, "flag after wrap");
        skip_sel = 1; tag = "R8"; idle(1);
        cmd(3'b100); idle(1);
        check("R8", {31'h0, skip_o}, 32'h0, "skip after clear");
        tag = "R3"; load(16'h0000); idle(1);
        check("R3", {31'h0, wrap_flag_o}, 32'h0, "load of zero leaves flag clear");

        tag = "R10"; load(16'hFFFF); wait_due();
        fn_strobe = 1; fn_word = 3'b100; step();
        check("R10", {31'h0, wrap_flag_o}, 32'h1, "clear loses to wrap");

        tag = "R9"; irq_enable = 1; idle(2); irq_enable = 0; idle(1);
        irq_enable = 1; cmd(3'b100); idle(1);

        tag = "R8"; fn_strobe = 0; fn_word = 3'b111; step(); idle(2);

        tag = "R4"; wait_due(); snap = m_cnt; cmd(3'b001); idle(DIV * 2);
        check("R4", {16'h0, count_o}, {16'h0, snap}, "no increment after halt");

        tag = "R2"; cmd(3'b010);
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 24) == 0) begin fn_strobe = 1; fn_word = 3'($urandom); end
            if (($urandom % 40) == 0) begin
                ld_en = 1;
                ld_data = ($urandom % 2) ? 16'($urandom) : 16'hFFF8 + 16'($urandom % 8);
            end
            if (($urandom % 32) == 0) irq_enable = ~irq_enable;
            skip_sel = 1'($urandom);
            step();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule